// File: doc/BRIEF.md
# Thermal Threshold Throttle Controller

This block watches the die temperature of a device. It accepts samples as whole degrees Celsius, with a strobe that marks each new sample. Each accepted sample is compared with two throttle limits and one trip limit, and each limit is set by configuration inputs. The result drives a 2-bit throttle code toward the clock-throttling logic. The first throttle tier is either 50% or 90%, chosen by a policy input. The second tier always forces 100% throttling. A separate sticky fatal flag asks the management controller to shut the device down.

Management software reads the state of the block through a small read-only window of 64-bit words. One word holds the limits, their enables, the status flags and the policy. A second word holds the last accepted temperature. A third word is a capability word. When its disable flag is set, none of the threshold logic acts.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: After synchronous reset, `throttle` is 00, `fatal_trip` is 0, `rd_valid` is 0, `rd_data` is zero, and the stored temperature and both status flags are zero.
- R2: A sample is accepted on a clock edge where `temp_valid` is 1. The throttle code and status flags change only on such edges, one cycle after the sample. Word 0x10 bits [6:0] return the last accepted temperature.
- R3: A sample at or above limit 1, with limit 1 enabled, sets status bit 32 of word 0x08. If limit 2 is not also reached, the throttle code becomes 01 (50%) when the policy input is 1, and 10 (90%) when the policy input is 0.
- R4: A sample at or above limit 2, with limit 2 enabled, sets status bit 33 and forces the throttle code to 11 (100%), whatever limit 1 and the policy are.
- R5: A limit whose enable is 0 never sets its status bit and never causes throttling.
- R6: A sample at or above the trip limit sets `fatal_trip`. Once set, `fatal_trip` stays 1 until reset, whatever the later samples are.
- R7: While the capability disable input is 1, a sample sets no status bit, produces throttle code 00 and does not raise `fatal_trip`. Bit 0 of word 0x20 reads back the disable input.
- R8: Word 0x08 carries limit 1 in [6:0], its enable in bit 7, limit 2 in [14:8], its enable in bit 15, the trip limit in [30:24], and the policy in bit 44. All other bits of this word read 0, apart from status bits 32 and 33.
- R9: A read strobe returns its word on `rd_data` with `rd_valid` high on the next cycle. Every offset other than 0x08, 0x10 and 0x20 reads as zero.
- R10: A sample exactly equal to a limit counts as reaching it. A sample one degree below the limit does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_valid | input | 1 | Strobe that accepts `temp_in` |
| temp_in | input | 7 | Temperature sample, degrees Celsius |
| cfg_lim1 | input | 7 | Throttle limit 1 |
| cfg_lim1_en | input | 1 | Enable for limit 1 |
| cfg_lim2 | input | 7 | Throttle limit 2 |
| cfg_lim2_en | input | 1 | Enable for limit 2 |
| cfg_trip | input | 7 | Fatal trip limit |
| cfg_policy | input | 1 | Tier 1 policy: 1 = 50%, 0 = 90% |
| cfg_disable | input | 1 | Capability disable for all threshold logic |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 64 | Read data, registered |
| rd_valid | output | 1 | Read data valid |
| throttle | output | 2 | Throttle code: 00 none, 01 50%, 10 90%, 11 100% |
| fatal_trip | output | 1 | Sticky shutdown request |

## Verification
The assertions assume that the configuration inputs are steady on the edge that accepts a sample, so that a decision can be traced to the limits and policy of that edge. They also assume that a read address is meaningful only in the cycle its strobe is high. The stimulus changes configuration only while `temp_valid` is low. It raises each strobe for a single cycle, with fresh data driven on the falling edge. The sample table walks temperatures across both throttle limits and their exact boundary values. Directed steps then cover policy, enables, the disable flag, the trip limit and unmapped reads.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  localparam int TEMP_W = 7;
  localparam int WORD_W = 64;
  localparam int ADDR_W = 8;

  // register window offsets (software decodes these)
  localparam logic [ADDR_W-1:0] OFF_LIMITS = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_TEMP   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CAP    = 8'h20;

  // bit positions inside the limits word
  localparam int POS_LIM1   = 0;
  localparam int POS_LIM1EN = 7;
  localparam int POS_LIM2   = 8;
  localparam int POS_LIM2EN = 15;
  localparam int POS_TRIP   = 24;
  localparam int POS_HIT1   = 32;
  localparam int POS_HIT2   = 33;
  localparam int POS_POLICY = 44;

  typedef enum logic [1:0] {
    THR_NONE   = 2'b00,
    THR_HALF   = 2'b01,
    THR_NINETY = 2'b10,
    THR_FULL   = 2'b11
  } throttle_e;
endpackage

// File: rtl/thermal_cmp.sv
module thermal_cmp
  import thermal_pkg::*;
#(
  parameter int TW = TEMP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [TW-1:0] smp_temp,
  input  logic [TW-1:0] lim1,
  input  logic          lim1_en,
  input  logic [TW-1:0] lim2,
  input  logic          lim2_en,
  input  logic [TW-1:0] trip,
  input  logic          policy,
  input  logic          disable_all,
  output logic          hit1_q,
  output logic          hit2_q,
  output logic [1:0]    level_q,
  output logic          fatal_q,
  output logic [TW-1:0] temp_q
);
  logic      hit1, hit2, hit_trip;
  throttle_e level_next;

  always_comb begin
    hit1     = !disable_all && lim1_en && (smp_temp >= lim1);
    hit2     = !disable_all && lim2_en && (smp_temp >= lim2);
    hit_trip = !disable_all && (smp_temp >= trip);
    if (hit2)      level_next = THR_FULL;
    else if (hit1) level_next = policy ? THR_HALF : THR_NINETY;
    else           level_next = THR_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit1_q  <= 1'b0;
      hit2_q  <= 1'b0;
      level_q <= THR_NONE;
      fatal_q <= 1'b0;
      temp_q  <= '0;
    end else begin
      if (smp_valid) begin
        hit1_q  <= hit1;
        hit2_q  <= hit2;
        level_q <= level_next;
        temp_q  <= smp_temp;
      end
      fatal_q <= fatal_q | (smp_valid & hit_trip);
    end
  end

  // R6: shutdown request never drops without reset
  a_r6_fatal_sticky: assert property (@(posedge clk) disable iff (rst)
    fatal_q |=> fatal_q);

  // R2: no sample, no change of throttle code
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(level_q) && $stable(hit1_q) && $stable(hit2_q));

  // R4: tier 2 status always pairs with full throttle
  a_r4_full: assert property (@(posedge clk) disable iff (rst)
    hit2_q |-> level_q == 2'b11);

  // R5: both limits off means no throttling at all
  a_r5_gate: assert property (@(posedge clk) disable iff (rst)
    smp_valid && !lim1_en && !lim2_en |=> level_q == 2'b00 && !hit1_q && !hit2_q);

  // R7: disabled capability blocks every reaction
  a_r7_disable: assert property (@(posedge clk) disable iff (rst)
    smp_valid && disable_all && !fatal_q |=> level_q == 2'b00 && !fatal_q && !hit1_q && !hit2_q);

  // R3: tier 1 only follows the policy
  a_r3_policy: assert property (@(posedge clk) disable iff (rst)
    hit1_q && !hit2_q |-> level_q == 2'b01 || level_q == 2'b10);
endmodule

// File: rtl/thermal_regs.sv
module thermal_regs
  import thermal_pkg::*;
#(
  parameter int TW = TEMP_W,
  parameter int AW = ADDR_W,
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic [TW-1:0] lim1,
  input  logic          lim1_en,
  input  logic [TW-1:0] lim2,
  input  logic          lim2_en,
  input  logic [TW-1:0] trip,
  input  logic          policy,
  input  logic          disable_all,
  input  logic          hit1,
  input  logic          hit2,
  input  logic [TW-1:0] temp,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [DW-1:0] w_limits, w_temp, w_cap, w_sel;
  logic          mapped;

  always_comb begin
    w_limits = '0;
    w_limits[POS_LIM1 +: TW] = lim1;
    w_limits[POS_LIM1EN]     = lim1_en;
    w_limits[POS_LIM2 +: TW] = lim2;
    w_limits[POS_LIM2EN]     = lim2_en;
    w_limits[POS_TRIP +: TW] = trip;
    w_limits[POS_HIT1]       = hit1;
    w_limits[POS_HIT2]       = hit2;
    w_limits[POS_POLICY]     = policy;
    w_temp        = '0;
    w_temp[0 +: TW] = temp;
    w_cap         = '0;
    w_cap[0]      = disable_all;
    mapped = 1'b1;
    case (rd_addr)
      OFF_LIMITS: w_sel = w_limits;
      OFF_TEMP:   w_sel = w_temp;
      OFF_CAP:    w_sel = w_cap;
      default: begin
        w_sel  = '0;
        mapped = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= w_sel;
    end
  end

  // R9: one-cycle read latency
  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R9: holes in the map return zero
  a_r9_unmapped: assert property (@(posedge clk) disable iff (rst)
    rd_en && !mapped |=> rd_data == '0);
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
  import thermal_pkg::*;
#(
  parameter int TW = TEMP_W,
  parameter int AW = ADDR_W,
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          temp_valid,
  input  logic [TW-1:0] temp_in,
  input  logic [TW-1:0] cfg_lim1,
  input  logic          cfg_lim1_en,
  input  logic [TW-1:0] cfg_lim2,
  input  logic          cfg_lim2_en,
  input  logic [TW-1:0] cfg_trip,
  input  logic          cfg_policy,
  input  logic          cfg_disable,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [1:0]    throttle,
  output logic          fatal_trip
);
  logic          hit1_q, hit2_q;
  logic [TW-1:0] temp_q;

  thermal_cmp #(.TW(TW)) u_cmp (
    .clk(clk), .rst(rst),
    .smp_valid(temp_valid), .smp_temp(temp_in),
    .lim1(cfg_lim1), .lim1_en(cfg_lim1_en),
    .lim2(cfg_lim2), .lim2_en(cfg_lim2_en),
    .trip(cfg_trip), .policy(cfg_policy), .disable_all(cfg_disable),
    .hit1_q(hit1_q), .hit2_q(hit2_q),
    .level_q(throttle), .fatal_q(fatal_trip), .temp_q(temp_q)
  );

  thermal_regs #(.TW(TW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .lim1(cfg_lim1), .lim1_en(cfg_lim1_en),
    .lim2(cfg_lim2), .lim2_en(cfg_lim2_en),
    .trip(cfg_trip), .policy(cfg_policy), .disable_all(cfg_disable),
    .hit1(hit1_q), .hit2(hit2_q), .temp(temp_q),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/sim_thermal_throttle_ctrl.sv
`timescale 1ns/1ps
module sim_thermal_throttle_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        temp_valid = 1'b0;
  logic [6:0]  temp_in = '0;
  logic [6:0]  cfg_lim1 = 7'd70, cfg_lim2 = 7'd90, cfg_trip = 7'd110;
  logic        cfg_lim1_en = 1'b1, cfg_lim2_en = 1'b1;
  logic        cfg_policy = 1'b1, cfg_disable = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic        rd_valid;
  logic [1:0]  throttle;
  logic        fatal_trip;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  thermal_throttle_ctrl u0 (
    .clk(clk), .rst(rst), .temp_valid(temp_valid), .temp_in(temp_in),
    .cfg_lim1(cfg_lim1), .cfg_lim1_en(cfg_lim1_en),
    .cfg_lim2(cfg_lim2), .cfg_lim2_en(cfg_lim2_en),
    .cfg_trip(cfg_trip), .cfg_policy(cfg_policy), .cfg_disable(cfg_disable),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .throttle(throttle), .fatal_trip(fatal_trip)
  );

  // {temp, expected throttle, expected hit1, expected hit2}
  // limits 70 / 90, trip 110, policy 1 (50%)
  localparam logic [10:0] VEC [0:7] = '{
    {7'd20,  2'b00, 1'b0, 1'b0},
    {7'd69,  2'b00, 1'b0, 1'b0},   // R10 one below
    {7'd70,  2'b01, 1'b1, 1'b0},   // R10 equal
    {7'd89,  2'b01, 1'b1, 1'b0},
    {7'd90,  2'b11, 1'b1, 1'b1},   // R4
    {7'd105, 2'b11, 1'b1, 1'b1},
    {7'd75,  2'b01, 1'b1, 1'b0},
    {7'd30,  2'b00, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sample(input logic [6:0] t);
    @(negedge clk);
    temp_in = t;
    temp_valid = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d, input string req);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, {63'd0, rd_valid}, 64'd1);
    d = rd_data;
  endtask

  function automatic logic [63:0] lim_word(logic h1, logic h2);
    logic [63:0] w = '0;
    w[6:0] = cfg_lim1;  w[7] = cfg_lim1_en;
    w[14:8] = cfg_lim2; w[15] = cfg_lim2_en;
    w[30:24] = cfg_trip;
    w[32] = h1; w[33] = h2; w[44] = cfg_policy;
    return w;
  endfunction

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 throttle", {62'd0, throttle}, 64'd0);
    chk("R1 fatal", {63'd0, fatal_trip}, 64'd0);
    chk("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
    chk("R1 rd_data", rd_data, 64'd0);
    rd(8'h10, d, "R9 valid");
    chk("R1 temp zero", d, 64'd0);
    rd(8'h08, d, "R9 valid");
    chk("R8 limits word after reset", d, lim_word(1'b0, 1'b0));

    // table walk: R3 R4 R10
    for (int i = 0; i < 8; i++) begin
      sample(VEC[i][10:4]);
      chk("R3/R4/R10 throttle", {62'd0, throttle}, {62'd0, VEC[i][3:2]});
      rd(8'h08, d, "R9 valid");
      chk("R3/R4 status word", d, lim_word(VEC[i][1], VEC[i][0]));
      rd(8'h10, d, "R9 valid");
      chk("R2 temperature word", d, {57'd0, VEC[i][10:4]});
      chk("R6 no trip below limit", {63'd0, fatal_trip}, 64'd0);
    end

    // R3 policy 0 -> 90%
    cfg_policy = 1'b0;
    sample(7'd80);
    chk("R3 policy0 throttle", {62'd0, throttle}, 64'd2);
    // R4 overrides policy
    sample(7'd95);
    chk("R4 override", {62'd0, throttle}, 64'd3);

    // R2 hold without strobe
    @(negedge clk);
    temp_in = 7'd10;
    repeat (3) @(negedge clk);
    chk("R2 hold throttle", {62'd0, throttle}, 64'd3);
    rd(8'h10, d, "R9 valid");
    chk("R2 hold temperature", d, 64'd95);

    // R5 enables cleared
    cfg_lim1_en = 1'b0;
    cfg_lim2_en = 1'b0;
    sample(7'd100);
    chk("R5 no throttle", {62'd0, throttle}, 64'd0);
    rd(8'h08, d, "R9 valid");
    chk("R5 no status", d, lim_word(1'b0, 1'b0));
    cfg_lim1_en = 1'b1;
    sample(7'd100);
    chk("R5 only limit2 off", {62'd0, throttle}, 64'd2);

    // R7 disable
    cfg_lim2_en = 1'b1;
    cfg_disable = 1'b1;
    sample(7'd120);
    chk("R7 throttle off", {62'd0, throttle}, 64'd0);
    chk("R7 no fatal", {63'd0, fatal_trip}, 64'd0);
    rd(8'h08, d, "R9 valid");
    chk("R7 status clear", d, lim_word(1'b0, 1'b0));
    rd(8'h20, d, "R9 valid");
    chk("R7 capability bit", d, 64'd1);
    cfg_disable = 1'b0;
    rd(8'h20, d, "R9 valid");
    chk("R7 capability clear", d, 64'd0);

    // R6 trip, R10 boundary
    sample(7'd109);
    chk("R10 trip one below", {63'd0, fatal_trip}, 64'd0);
    sample(7'd110);
    chk("R6 trip set", {63'd0, fatal_trip}, 64'd1);
    sample(7'd20);
    chk("R6 sticky", {63'd0, fatal_trip}, 64'd1);
    chk("R6 throttle recovers", {62'd0, throttle}, 64'd0);

    // R9 unmapped
    rd(8'h00, d, "R9 valid");
    chk("R9 unmapped 00", d, 64'd0);
    rd(8'h18, d, "R9 valid");
    chk("R9 unmapped 18", d, 64'd0);
    rd(8'h09, d, "R9 valid");
    chk("R9 unmapped 09", d, 64'd0);

    // R1 reset clears fatal
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 fatal cleared", {63'd0, fatal_trip}, 64'd0);
    chk("R1 throttle cleared", {62'd0, throttle}, 64'd0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule